// File: doc/BRIEF.md
# Immediate-Shift and Upper-Immediate Execute Unit

This unit executes five RV32I integer instructions in a single registered stage: the three shifts whose amount comes from the instruction word (logical left, logical right, arithmetic right) and the two U-type forms (load upper immediate, and add upper immediate to the program counter). The surrounding pipeline presents an instruction word with a valid strobe, the current PC and the value already read from the source register. One cycle later the unit returns the destination index, the 32-bit result, a write-enable and an illegal-instruction flag.

A single barrel shifter serves all three shift kinds. Left shifts reverse the operand's bit order on the way in and on the way out. The two right shifts share the same encoding except for instruction bit 30, which selects the arithmetic form. Any word outside the five supported encodings is refused: the illegal flag rises and no write is requested.

Top module: `shup_exec`

## Requirements
- R1: A word with opcode 0010011, funct3 001 and bits [31:25] all zero is a left shift. The result is the source shifted left by bits [24:20], with zeros filling the low bits. rd_o takes bits [11:7]. Word 0x00361693 gives rd_o=13, and a source of 0x12345678 then gives 0x91A2B3C0.
- R2: Opcode 0010011, funct3 101 and bits [31:25] zero is a logical right shift, with zeros filling the high bits.
- R3: Opcode 0010011, funct3 101 and bits [31:25] equal to 0100000 (bit 30 set) is an arithmetic right shift. The high bits fill with copies of source bit 31.
- R4: The shift amount is bits [24:20], from 0 to 31. An amount of 0 returns the source unchanged for all three shift kinds.
- R5: Opcode 0110111 yields bits [31:12] of the word in result bits [31:12], with the low 12 bits zero. Word 0xF0000437 writes 0xF0000000 to rd 8.
- R6: Opcode 0010111 yields the PC plus ({bits[31:12],12'h000}), modulo 2^32. An immediate of zero returns the PC.
- R7: The source-register input has no effect on the result of the two U-type instructions.
- R8: Any other word is illegal. This covers shift words whose bits [31:25] are neither pattern above (including bit 30 set with funct3 001), and all other opcodes and funct3 values. An illegal word gives illegal_o=1, wen_o=0 and result_o=0.
- R9: When rd is 0, wen_o is 0 even for a legal word, and illegal_o stays 0.
- R10: Outputs update on the clock edge that samples valid_i high. In a cycle that follows an edge with valid_i low, wen_o and illegal_o are 0, and rd_o and result_o hold their values.
- R11: An active-low reset clears rd_o, result_o, wen_o and illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | PC of the instruction |
| src_i | input | 32 | Value read from the source register |
| rd_o | output | 5 | Destination register index |
| result_o | output | 32 | Result to write back |
| wen_o | output | 1 | Write request to the register file |
| illegal_o | output | 1 | Word is not one of the five supported instructions |

## Verification
On every cycle the assertions check the following:
- wen_o and illegal_o are never both high.
- A write never targets register 0.
- Both flags stay low after an idle edge.
- A zero-amount shift returns its operand.
- An arithmetic shift keeps the sign bit.
- The upper-immediate load clears the low 12 bits.

The exact shifted values, the PC-relative sums and their wrap-around, and the fact that the source is ignored for U-type words can only be shown by the bench scenarios. Those scenarios compare every result against an independent model, over random and hand-picked words.

// File: rtl/shup_pkg.sv
package shup_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned SHW  = $clog2(XLEN);

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [2:0] F3_SLL    = 3'b001;
  localparam logic [2:0] F3_SRX    = 3'b101;
  localparam logic [6:0] F7_BASE   = 7'b0000000;
  localparam logic [6:0] F7_ARITH  = 7'b0100000;

  typedef enum logic [2:0] {
    OP_SLL, OP_SRL, OP_SRA, OP_LUI, OP_AUIPC, OP_BAD
  } op_e;
endpackage

// File: rtl/shup_decode.sv
module shup_decode
  import shup_pkg::*;
(
  input  logic [31:0] instr_i,
  output op_e         op_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];

  always_comb begin
    op_o = OP_BAD;
    unique case (opc)
      OPC_LUI:   op_o = OP_LUI;
      OPC_AUIPC: op_o = OP_AUIPC;
      OPC_IMM: begin
        if (f3 == F3_SLL && f7 == F7_BASE)       op_o = OP_SLL;
        else if (f3 == F3_SRX && f7 == F7_BASE)  op_o = OP_SRL;
        else if (f3 == F3_SRX && f7 == F7_ARITH) op_o = OP_SRA;
      end
      default: op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/shup_barrel.sv
module shup_barrel #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AW-1:0]    amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [0:AW];
  logic [WIDTH-1:0] rev_in, last;
  logic             fill;

  // left shift = reverse, shift right, reverse
  always_comb begin
    for (int i = 0; i < WIDTH; i++) rev_in[i] = data_i[WIDTH-1-i];
  end

  assign stage[0] = left_i ? rev_in : data_i;
  assign fill     = arith_i & ~left_i & data_i[WIDTH-1];

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{S{fill}}, stage[k][WIDTH-1:S]} : stage[k];
  end

  assign last = stage[AW];

  always_comb begin
    data_o = last;
    if (left_i) begin
      for (int i = 0; i < WIDTH; i++) data_o[i] = last[WIDTH-1-i];
    end
  end
endmodule

// File: rtl/shup_upper.sv
module shup_upper
  import shup_pkg::*;
(
  input  logic [19:0]     imm_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            add_pc_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] imm_ext;

  assign imm_ext = {imm_i, 12'h000};
  assign data_o  = add_pc_i ? (pc_i + imm_ext) : imm_ext;  // wraps mod 2^32
endmodule

// File: rtl/shup_exec.sv
module shup_exec
  import shup_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] src_i,
  output logic [4:0]      rd_o,
  output logic [XLEN-1:0] result_o,
  output logic            wen_o,
  output logic            illegal_o
);
  op_e             op;
  logic            legal, is_shift;
  logic [SHW-1:0]  amt;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] sh_res, up_res, nxt_res;

  assign amt    = instr_i[20 +: SHW];
  assign rd_idx = instr_i[11:7];

  shup_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op)
  );

  shup_barrel #(.WIDTH(XLEN)) u_sh (
    .data_i  (src_i),
    .amt_i   (amt),
    .left_i  (op == OP_SLL),
    .arith_i (op == OP_SRA),
    .data_o  (sh_res)
  );

  shup_upper u_up (
    .imm_i    (instr_i[31:12]),
    .pc_i     (pc_i),
    .add_pc_i (op == OP_AUIPC),
    .data_o   (up_res)
  );

  assign is_shift = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  assign legal    = (op != OP_BAD);

  always_comb begin
    if (is_shift)   nxt_res = sh_res;
    else if (legal) nxt_res = up_res;
    else            nxt_res = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o      <= '0;
      result_o  <= '0;
      wen_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wen_o     <= valid_i & legal & (rd_idx != 5'd0);
      illegal_o <= valid_i & ~legal;
      if (valid_i) begin
        rd_o     <= rd_idx;
        result_o <= nxt_res;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wen_o && illegal_o)); // R8
  AST_NO_X0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_o |-> rd_o != 5'd0); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wen_o && !illegal_o); // R10
  AST_ZERO_AMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_shift && amt == '0 |=> result_o == $past(src_i)); // R4
  AST_SRA_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_SRA |=> result_o[XLEN-1] == $past(src_i[XLEN-1])); // R3
  AST_LUI_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_LUI |=> result_o[11:0] == 12'h000); // R5
endmodule

// File: tb/shup_exec_bench.sv
module shup_exec_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0, pc_i = '0, src_i = '0;
  logic [4:0]  rd_o;
  logic [31:0] result_o;
  logic        wen_o, illegal_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  shup_exec u_shup_exec (
    .clk_i, .rst_ni, .valid_i, .instr_i, .pc_i, .src_i,
    .rd_o, .result_o, .wen_o, .illegal_o
  );

  // {wen, illegal, rd, result}
  function automatic logic [38:0] model(logic [31:0] w, logic [31:0] pc, logic [31:0] s);
    logic [6:0]  opc = w[6:0];
    logic [2:0]  f3  = w[14:12];
    logic [6:0]  f7  = w[31:25];
    logic [4:0]  sh  = w[24:20];
    logic [4:0]  rd  = w[11:7];
    logic [31:0] r   = '0;
    logic        ok  = 1'b1;
    if (opc == 7'h13 && f3 == 3'd1 && f7 == 7'h00)      r = s << sh;
    else if (opc == 7'h13 && f3 == 3'd5 && f7 == 7'h00) r = s >> sh;
    else if (opc == 7'h13 && f3 == 3'd5 && f7 == 7'h20) r = $unsigned($signed(s) >>> sh);
    else if (opc == 7'h37)                              r = {w[31:12], 12'h000};
    else if (opc == 7'h17)                              r = pc + {w[31:12], 12'h000};
    else ok = 1'b0;
    return {ok && rd != 5'd0, !ok, rd, r};
  endfunction

  function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] sh, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] opc);
    return {f7, sh, 5'd12, f3, rd, opc};
  endfunction

  task automatic cmp(string tag, logic [38:0] got, logic [38:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual wen=%b ill=%b rd=%0d res=%h expected wen=%b ill=%b rd=%0d res=%h",
               tag, got[38], got[37], got[36:32], got[31:0], exp[38], exp[37], exp[36:32], exp[31:0]);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic issue(string tag, logic [31:0] w, logic [31:0] pc, logic [31:0] s);
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = w; pc_i = pc; src_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
    cmp(tag, {wen_o, illegal_o, rd_o, result_o}, model(w, pc, s));
  endtask

  task automatic issue_exp(string tag, logic [31:0] w, logic [31:0] pc, logic [31:0] s,
                           logic [38:0] exp);
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = w; pc_i = pc; src_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
    cmp(tag, {wen_o, illegal_o, rd_o, result_o}, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [38:0] hold;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    cmp("R11 reset", {wen_o, illegal_o, rd_o, result_o}, 39'd0);
    rst_ni = 1'b1;

    // directed
    issue_exp("R1 slli word", 32'h00361693, 32'h0, 32'h12345678, {1'b1, 1'b0, 5'd13, 32'h91A2B3C0});
    issue_exp("R5 lui word", 32'hF0000437, 32'h0, 32'hDEADBEEF, {1'b1, 1'b0, 5'd8, 32'hF0000000});
    issue_exp("R6 auipc zero", enc(7'h00, 5'd0, 3'd0, 5'd12, 7'h17) & 32'h00000FFF,
              32'h00401234, 32'h55555555, {1'b1, 1'b0, 5'd12, 32'h00401234});
    issue_exp("R6 auipc wrap", 32'hFFFFF617, 32'h00002000, 32'h0, {1'b1, 1'b0, 5'd12, 32'h00001000});
    issue_exp("R7 auipc src ignored", 32'h00F00617, 32'h00000100, 32'hFFFFFFFF, {1'b1, 1'b0, 5'd12, 32'h00F00100});
    issue_exp("R3 srai sign", enc(7'h20, 5'd3, 3'd5, 5'd13, 7'h13), 32'h0, 32'hCC000000,
              {1'b1, 1'b0, 5'd13, 32'hF9800000});
    issue_exp("R2 srli zero", enc(7'h00, 5'd3, 3'd5, 5'd13, 7'h13), 32'h0, 32'hCC000000,
              {1'b1, 1'b0, 5'd13, 32'h19800000});
    issue_exp("R3 srai 31", enc(7'h20, 5'd31, 3'd5, 5'd1, 7'h13), 32'h0, 32'h80000000,
              {1'b1, 1'b0, 5'd1, 32'hFFFFFFFF});
    issue_exp("R1 slli 31", enc(7'h00, 5'd31, 3'd1, 5'd1, 7'h13), 32'h0, 32'h00000003,
              {1'b1, 1'b0, 5'd1, 32'h80000000});
    issue_exp("R4 srai amt0", enc(7'h20, 5'd0, 3'd5, 5'd2, 7'h13), 32'h0, 32'hA5A5A5A5,
              {1'b1, 1'b0, 5'd2, 32'hA5A5A5A5});
    issue_exp("R4 slli amt0", enc(7'h00, 5'd0, 3'd1, 5'd2, 7'h13), 32'h0, 32'h5A5A5A5A,
              {1'b1, 1'b0, 5'd2, 32'h5A5A5A5A});
    issue_exp("R8 slli bit30", enc(7'h20, 5'd3, 3'd1, 5'd4, 7'h13), 32'h0, 32'h1,
              {1'b0, 1'b1, 5'd4, 32'h0});
    issue_exp("R8 srli bit25", enc(7'h01, 5'd3, 3'd5, 5'd4, 7'h13), 32'h0, 32'h1,
              {1'b0, 1'b1, 5'd4, 32'h0});
    issue_exp("R8 addi refused", enc(7'h00, 5'd3, 3'd0, 5'd4, 7'h13), 32'h0, 32'h1,
              {1'b0, 1'b1, 5'd4, 32'h0});
    issue_exp("R9 rd zero", enc(7'h00, 5'd2, 3'd1, 5'd0, 7'h13), 32'h0, 32'h1,
              {1'b0, 1'b0, 5'd0, 32'h4});

    // idle: flags drop, data holds
    hold = {1'b0, 1'b0, rd_o, result_o};
    @(negedge clk_i);
    cmp("R10 idle", {wen_o, illegal_o, rd_o, result_o}, hold);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w, pc, s;
      int kind;
      kind = $urandom_range(0, 6);
      pc = $urandom; s = $urandom; w = $urandom;
      case (kind)
        0: issue("R1 rand slli", enc(7'h00, w[24:20], 3'd1, w[11:7], 7'h13), pc, s);
        1: issue("R2 rand srli", enc(7'h00, w[24:20], 3'd5, w[11:7], 7'h13), pc, s);
        2: issue("R3 rand srai", enc(7'h20, w[24:20], 3'd5, w[11:7], 7'h13), pc, s);
        3: issue("R5 rand lui", {w[31:7], 7'h37}, pc, s);
        4: issue("R6 rand auipc", {w[31:7], 7'h17}, pc, s);
        5: issue("R8 rand word", w, pc, s);
        default: issue("R8 rand shift f7", {w[31:25], w[24:15], (w[12] ? 3'd5 : 3'd1), w[11:7], 7'h13}, pc, s);
      endcase
      if (n % 37 == 0) begin
        @(negedge clk_i);
        checks++;
        if (wen_o || illegal_o) begin
          errors++;
          $display("FAIL R10 idle flags: actual wen=%b ill=%b expected 0 0", wen_o, illegal_o);
        end
      end
    end

    // reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    cmp("R11 reset again", {wen_o, illegal_o, rd_o, result_o}, 39'd0);

    summary();
    $finish;
  end
endmodule